// File: doc/BRIEF.md
# Indexed Load/Store Address Generator

This block forms the effective address for memory accesses that combine a 64-bit base register with an index register. The index is conditioned by a three-bit extend selector: it can be taken as its low 32 bits zero-filled, as its low 32 bits sign-filled, or as the full 64-bit value. It can then be shifted left by the log2 of the access size, and it is added to the base. Selector codes that name a byte or halfword source are not legal for this kind of access. For those codes the block raises an undefined-encoding flag and forces the address to zero.

The selector uses the same layout as the arithmetic extend selector. Bit 2 carries signedness and bits 1:0 carry the source width (00 byte, 01 halfword, 10 word, 11 doubleword). Only the word and doubleword widths are accepted here. The two doubleword codes are separate encodings, and both pass the index through untouched. The caller resolves register 31 to the stack pointer before the base reaches the block, so the base always arrives as a full 64-bit value. Both outputs are registered, with a synchronous active-high reset.

Top module: `ldst_idx_agu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `addr_q` and `undef_q` are zero after that edge.
- R2: `undef_q` is 1 exactly when bit 1 of the `ext_sel` sampled at the previous edge was 0 (codes 000, 001, 100, 101).
- R3: Whenever `undef_q` is 1, `addr_q` is zero.
- R4: Selector 010 zero-fills bits 63:32 of the index, using only the index's bits 31:0.
- R5: Selector 110 copies index bit 31 into bits 63:32 of the index.
- R6: Selectors 011 and 111 use all 64 index bits unchanged and give identical addresses for the same operands.
- R7: With `scale_en` = 0 the conditioned index is added with no shift, whatever the value of `size_lg2`.
- R8: With `scale_en` = 1 the conditioned index is shifted left by `size_lg2` (0 to 3) before the add.
- R9: The sum of base and offset wraps modulo 2^64, and no carry or overflow is reported.
- R10: Each result appears on the outputs exactly one clock edge after its operands are sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_val | input | 64 | Base register value (stack pointer already resolved) |
| index_val | input | 64 | Index register value |
| ext_sel | input | 3 | Extend selector: bit 2 signed, bits 1:0 source width |
| scale_en | input | 1 | Scale the index by the access size |
| size_lg2 | input | 2 | log2 of the access size in bytes |
| addr_q | output | 64 | Registered effective address |
| undef_q | output | 1 | Registered undefined-encoding flag |

## Verification
Every result is due one rising edge after its operands are applied, because the outputs pass through a single register stage. The bench applies operands, waits for the next rising edge and samples one nanosecond later. At that point it compares both outputs against a behavioural model computed from the same operands. The sign-fill, wrap-around and doubleword-equivalence cases each have their own operand patterns, so each check falls on the cycle its result belongs to.

// File: rtl/ldst_agu_pkg.sv
package ldst_agu_pkg;
  localparam int ADDR_W   = 64;
  localparam int NARROW_W = 32;
  localparam int SEL_W    = 3;
  localparam int SZ_W     = 2;

  typedef enum logic [1:0] {
    SRC_BYTE  = 2'b00,
    SRC_HALF  = 2'b01,
    SRC_WORD  = 2'b10,
    SRC_DWORD = 2'b11
  } src_width_e;

  typedef struct packed {
    logic       is_signed;
    src_width_e width;
  } ext_sel_t;

  function automatic logic sel_is_legal(ext_sel_t s);
    return s.width[1];
  endfunction
endpackage

// File: rtl/ldst_idx_extend.sv
module ldst_idx_extend
  import ldst_agu_pkg::*;
#(
  parameter int W  = ADDR_W,
  parameter int NW = NARROW_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] idx_in,
  input  ext_sel_t     sel,
  output logic [W-1:0] idx_ext,
  output logic         illegal
);
  localparam int FILL_W = W - NW;

  logic [FILL_W-1:0] fill_bits;

  generate
    if (FILL_W > 0) begin : g_fill
      always_comb begin
        fill_bits = sel.is_signed ? {FILL_W{idx_in[NW-1]}} : '0;
      end
    end else begin : g_nofill
      always_comb fill_bits = '0;
    end
  endgenerate

  always_comb begin
    illegal = !sel_is_legal(sel);
    unique case (sel.width)
      SRC_WORD:  idx_ext = {fill_bits, idx_in[NW-1:0]};
      SRC_DWORD: idx_ext = idx_in;
      default:   idx_ext = '0;
    endcase
  end

  p_zero_fill_r4: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'b010) |-> (idx_ext[W-1:NW] == '0 && idx_ext[NW-1:0] == idx_in[NW-1:0]));

  p_sign_fill_r5: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'b110) |-> (idx_ext[W-1:NW] == {FILL_W{idx_in[NW-1]}}));

  p_dword_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (sel.width == SRC_DWORD) |-> (idx_ext == idx_in));
endmodule

// File: rtl/ldst_idx_scale.sv
module ldst_idx_scale
  import ldst_agu_pkg::*;
#(
  parameter int W    = ADDR_W,
  parameter int SZW  = SZ_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   din,
  input  logic           scale_en,
  input  logic [SZW-1:0] size_lg2,
  output logic [W-1:0]   dout
);
  logic [SZW-1:0] shamt;

  always_comb begin
    shamt = scale_en ? size_lg2 : '0;
    dout  = din << shamt;
  end

  p_no_scale_r7: assert property (@(posedge clk) disable iff (rst)
    !scale_en |-> (dout == din));

  p_scale_lsb_r8: assert property (@(posedge clk) disable iff (rst)
    (scale_en && size_lg2 == 2'd3) |-> (dout[2:0] == 3'b000));
endmodule

// File: rtl/ldst_addr_add.sv
module ldst_addr_add
  import ldst_agu_pkg::*;
#(
  parameter int W = ADDR_W
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] offset,
  output logic [W-1:0] sum
);
  always_comb sum = base + offset;
endmodule

// File: rtl/ldst_idx_agu.sv
module ldst_idx_agu
  import ldst_agu_pkg::*;
#(
  parameter int W   = ADDR_W,
  parameter int NW  = NARROW_W,
  parameter int SZW = SZ_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   base_val,
  input  logic [W-1:0]   index_val,
  input  logic [2:0]     ext_sel,
  input  logic           scale_en,
  input  logic [SZW-1:0] size_lg2,
  output logic [W-1:0]   addr_q,
  output logic           undef_q
);
  ext_sel_t     sel_s;
  logic [W-1:0] idx_ext;
  logic [W-1:0] idx_scaled;
  logic [W-1:0] addr_sum;
  logic         illegal;

  always_comb sel_s = ext_sel_t'(ext_sel);

  ldst_idx_extend #(.W(W), .NW(NW)) u_ext (
    .clk(clk), .rst(rst), .idx_in(index_val), .sel(sel_s),
    .idx_ext(idx_ext), .illegal(illegal)
  );

  ldst_idx_scale #(.W(W), .SZW(SZW)) u_scale (
    .clk(clk), .rst(rst), .din(idx_ext), .scale_en(scale_en),
    .size_lg2(size_lg2), .dout(idx_scaled)
  );

  ldst_addr_add #(.W(W)) u_add (
    .base(base_val), .offset(idx_scaled), .sum(addr_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      undef_q <= 1'b0;
    end else begin
      undef_q <= illegal;
      addr_q  <= illegal ? '0 : addr_sum;
    end
  end

  p_undef_flag_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (undef_q == !$past(ext_sel[1])));

  p_undef_zero_r3: assert property (@(posedge clk) disable iff (rst)
    undef_q |-> (addr_q == '0));

  p_dword_alias_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ext_sel[1:0]) == 2'b11 && !$past(scale_en))
      |-> (addr_q == $past(base_val) + $past(index_val)));

  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (addr_q == '0 && !undef_q));
endmodule

// File: tb/tb_ldst_idx_agu.sv
module tb_ldst_idx_agu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] base_val = '0;
  logic [63:0] index_val = '0;
  logic [2:0]  ext_sel = 3'b010;
  logic        scale_en = 1'b0;
  logic [1:0]  size_lg2 = '0;
  logic [63:0] addr_q;
  logic        undef_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  ldst_idx_agu dut (
    .clk(clk), .rst(rst), .base_val(base_val), .index_val(index_val),
    .ext_sel(ext_sel), .scale_en(scale_en), .size_lg2(size_lg2),
    .addr_q(addr_q), .undef_q(undef_q)
  );

  function automatic void model(input logic [63:0] b, input logic [63:0] i,
                                input logic [2:0] s, input logic en,
                                input logic [1:0] lg,
                                output logic [63:0] a, output logic u);
    longint unsigned off;
    u = 1'b0;
    case (s)
      3'b010: off = longint'(i[31:0]) & 64'h0000_0000_FFFF_FFFF;
      3'b110: off = unsigned'(longint'(signed'(i[31:0])));
      3'b011, 3'b111: off = i;
      default: begin off = 0; u = 1'b1; end
    endcase
    if (en) off = off * (64'd1 << lg);
    a = u ? 64'd0 : b + off;
  endfunction

  task automatic check(input string tag, input logic [63:0] ea, input logic eu);
    n_checks++;
    if (addr_q !== ea || undef_q !== eu) begin
      n_fail++;
      $display("FAIL %s: addr=%h undef=%b expected addr=%h undef=%b",
               tag, addr_q, undef_q, ea, eu);
    end
  endtask

  task automatic apply(input string tag, input logic [63:0] b, input logic [63:0] i,
                       input logic [2:0] s, input logic en, input logic [1:0] lg);
    logic [63:0] ea;
    logic eu;
    base_val = b; index_val = i; ext_sel = s; scale_en = en; size_lg2 = lg;
    model(b, i, s, en, lg, ea, eu);
    @(posedge clk); #1;
    check(tag, ea, eu);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: addr=%h undef=%b expected completion", addr_q, undef_q);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    base_val = 64'hDEAD_BEEF_0000_1234; index_val = 64'h55; ext_sel = 3'b001;
    repeat (3) @(posedge clk);
    #1 check("R1 reset", 64'd0, 1'b0);
    rst = 1'b0;
    apply("R4 zero-fill", 64'h1000, 64'hFFFF_FFFF_8000_0010, 3'b010, 1'b0, 2'd0);
    apply("R5 sign-fill neg", 64'h1000, 64'h0000_0000_8000_0010, 3'b110, 1'b0, 2'd0);
    apply("R5 sign-fill pos", 64'h1000, 64'hFFFF_FFFF_7000_0010, 3'b110, 1'b0, 2'd0);
    apply("R6 dword 011", 64'h1234_0000, 64'hABCD_0000_0000_0100, 3'b011, 1'b0, 2'd0);
    apply("R6 dword 111", 64'h1234_0000, 64'hABCD_0000_0000_0100, 3'b111, 1'b0, 2'd0);
    apply("R6 dword 111 scaled", 64'h20, 64'hF000_0000_0000_0004, 3'b111, 1'b1, 2'd3);
    apply("R6 dword 011 scaled", 64'h20, 64'hF000_0000_0000_0004, 3'b011, 1'b1, 2'd3);
    apply("R7 no scale", 64'h100, 64'h7, 3'b010, 1'b0, 2'd3);
    for (int k = 0; k < 4; k++)
      apply("R8 scale", 64'h100, 64'h7, 3'b010, 1'b1, 2'(k));
    apply("R8 sign-fill scaled", 64'h8000, 64'hFFFF_FFFF, 3'b110, 1'b1, 2'd2);
    apply("R9 wrap", 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 3'b011, 1'b0, 2'd0);
    apply("R9 wrap scaled", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 3'b111, 1'b1, 2'd1);
    apply("R2 R3 undef 000", 64'h1000, 64'h10, 3'b000, 1'b0, 2'd0);
    apply("R2 R3 undef 001", 64'h1000, 64'h10, 3'b001, 1'b1, 2'd2);
    apply("R2 R3 undef 100", 64'h1000, 64'h10, 3'b100, 1'b0, 2'd0);
    apply("R2 R3 undef 101", 64'h1000, 64'h10, 3'b101, 1'b1, 2'd3);
    apply("R2 recover", 64'h1000, 64'h10, 3'b010, 1'b0, 2'd0);
    base_val = 64'h4000; index_val = 64'h8; ext_sel = 3'b011; scale_en = 1'b0;
    #1 check("R10 not before edge", 64'h1010, 1'b0);
    @(posedge clk); #1 check("R10 one edge later", 64'h4008, 1'b0);
    rst = 1'b1;
    @(posedge clk); #1 check("R1 reset mid-run", 64'd0, 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule